// File: doc/BRIEF.md
# DMA Address Window Decoder

This block sits in front of a DMA engine's memory port and classifies each transfer address. For every request it reports which target is addressed (main memory, the scratchpad, a zero sink, or nothing at all) and the 16-byte aligned offset into that target. The memory arrays and the data movement stay outside the block.

Two paths lead to the scratchpad. Bit 31 of the address redirects the access there directly. A small physical window just above the zero-sink hole also maps there. Addresses between the end of main memory and that window fall into a sink: reads return zero and writes are discarded. Read and write sink accesses get separate region codes. Any other address is a bus error. An error produces a one-cycle set pulse for the requesting channel's status bit and a one-cycle stop pulse for that channel's start bit. It also sets a sticky bus-error flag, which stays set until software clears it.

Decode results are registered. They appear one cycle after the request strobe.

Top module: `dma_window_decode`

## Requirements
- R1: When address bit 31 is set, the region is scratchpad and the offset is address & 0x3FF0, whatever the other bits hold.
- R2: Without bit 31, the address is masked with 0x1FFFFFF0 before any range test, so bits 30, 29 and 3..0 never affect the result and every offset has its low four bits zero.
- R3: A masked address below MAIN_BYTES (default 0x02000000) selects main memory with offset equal to the masked address.
- R4: A masked address from MAIN_BYTES up to 0x0FFFFFFF selects the zero sink with offset 0. The region is zero-read for a read and zero-write for a write.
- R5: A masked address from 0x10000000 to 0x10003FFF selects the scratchpad at offset address & 0x3FF0.
- R6: Any other address gives region error and offset 0. It also gives a one-cycle err_pulse, a one-cycle status set vector equal to 1 << channel, and a one-cycle stop_pulse with stop_chan equal to the requesting channel.
- R7: Region codes are 0 main, 1 scratchpad, 2 zero-read, 3 zero-write and 4 error. Results and pulses appear one cycle after the request strobe, and rsp_valid is high for exactly that cycle. A cycle without the strobe produces no pulses.
- R8: buserr_flag is set by any error, holds until err_clear is asserted, and an error in the same cycle as err_clear leaves it set.
- R9: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Transfer address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_chan | input | CHW | Requesting channel number |
| err_clear | input | 1 | Software clear of the sticky bus-error flag |
| rsp_valid | output | 1 | Decode result valid |
| rsp_region | output | 3 | Region code |
| rsp_offset | output | 32 | Aligned offset into the region |
| err_pulse | output | 1 | One-cycle bus-error event |
| stat_set | output | CHANNELS | One-cycle per-channel status set vector |
| stop_pulse | output | 1 | One-cycle request to clear a channel's start bit |
| stop_chan | output | CHW | Channel whose start bit is cleared |
| buserr_flag | output | 1 | Sticky bus-error flag |

## Verification
The sticky flag has two update paths, a new error setting it and the software clear dropping it, and both can land on the same clock edge. The bench provokes this by raising err_clear in the same cycle as a request to an unmapped address on the highest channel. It judges the outcome by the flag still being high on the following cycle, next to a correct status vector for that channel. The bench also places a clear between two separate errors. This shows that the clear takes effect when no set competes with it.

// File: rtl/dma_window_decode.sv
module dma_window_decode #(
  parameter logic [31:0] MAIN_BYTES = 32'h0200_0000,
  parameter int          CHANNELS   = 16,
  parameter int          CHW        = $clog2(CHANNELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [31:0]         req_addr,
  input  logic                req_write,
  input  logic [CHW-1:0]      req_chan,
  input  logic                err_clear,
  output logic                rsp_valid,
  output logic [2:0]          rsp_region,
  output logic [31:0]         rsp_offset,
  output logic                err_pulse,
  output logic [CHANNELS-1:0] stat_set,
  output logic                stop_pulse,
  output logic [CHW-1:0]      stop_chan,
  output logic                buserr_flag
);
  localparam logic [31:0] PHYS_MASK = 32'h1FFF_FFF0;
  localparam logic [31:0] SPAD_MASK = 32'h0000_3FF0;
  localparam logic [31:0] HOLE_END  = 32'h1000_0000;
  localparam logic [31:0] SPAD_END  = 32'h1000_4000;
  localparam logic [2:0]  RG_MAIN = 3'd0, RG_SPAD = 3'd1, RG_ZRD = 3'd2,
                          RG_ZWR = 3'd3, RG_ERR = 3'd4;

  wire [31:0] phys     = req_addr & PHYS_MASK;
  wire [31:0] spad_off = req_addr & SPAD_MASK;

  logic [2:0]  region_d;
  logic [31:0] offset_d;

  always_comb begin
    region_d = RG_ERR;
    offset_d = '0;
    if (req_addr[31]) begin
      region_d = RG_SPAD;
      offset_d = spad_off;
    end else if (phys < MAIN_BYTES) begin
      region_d = RG_MAIN;
      offset_d = phys;
    end else if (phys < HOLE_END) begin
      region_d = req_write ? RG_ZWR : RG_ZRD;
    end else if (phys < SPAD_END) begin
      region_d = RG_SPAD;
      offset_d = spad_off;
    end
  end

  wire bad = req_valid && (region_d == RG_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_region  <= RG_MAIN;
      rsp_offset  <= '0;
      err_pulse   <= 1'b0;
      stat_set    <= '0;
      stop_pulse  <= 1'b0;
      stop_chan   <= '0;
      buserr_flag <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      err_pulse  <= bad;
      stop_pulse <= bad;
      stat_set   <= bad ? (CHANNELS'(1) << req_chan) : '0;
      if (req_valid) begin
        rsp_region <= region_d;
        rsp_offset <= offset_d;
      end
      if (bad) stop_chan <= req_chan;
      if (bad)            buserr_flag <= 1'b1;
      else if (err_clear) buserr_flag <= 1'b0;
    end
  end
endmodule

module dma_window_decode_chk #(
  parameter int CHANNELS = 16,
  parameter int CHW      = $clog2(CHANNELS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                err_clear,
  input logic                rsp_valid,
  input logic [2:0]          rsp_region,
  input logic [31:0]         rsp_offset,
  input logic                err_pulse,
  input logic [CHANNELS-1:0] stat_set,
  input logic                stop_pulse,
  input logic [CHW-1:0]      stop_chan,
  input logic                buserr_flag
);
  assert_valid_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_pulse_without_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !err_pulse && !stop_pulse && stat_set == '0));
  assert_offset_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_offset[3:0] == 4'h0);
  assert_spad_offset_small_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_region == 3'd1) |-> rsp_offset[31:14] == '0);
  assert_err_side_effects_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (rsp_valid && rsp_region == 3'd4 && stop_pulse &&
                   stat_set == (CHANNELS'(1) << stop_chan)));
  assert_err_region_pulses_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_region == 3'd4) |-> err_pulse);
  assert_flag_rises_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buserr_flag) |-> err_pulse);
  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buserr_flag) |-> $past(err_clear));
  assert_status_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_set));
endmodule

bind dma_window_decode dma_window_decode_chk #(.CHANNELS(CHANNELS), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .err_clear(err_clear),
  .rsp_valid(rsp_valid), .rsp_region(rsp_region), .rsp_offset(rsp_offset),
  .err_pulse(err_pulse), .stat_set(stat_set), .stop_pulse(stop_pulse),
  .stop_chan(stop_chan), .buserr_flag(buserr_flag)
);

// File: tb/test_dma_window_decode.sv
module test_dma_window_decode;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic          req_write = 1'b0;
  logic [CW-1:0] req_chan = '0;
  logic          err_clear = 1'b0;
  logic          rsp_valid, err_pulse, stop_pulse, buserr_flag;
  logic [2:0]    rsp_region;
  logic [31:0]   rsp_offset;
  logic [CH-1:0] stat_set;
  logic [CW-1:0] stop_chan;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_window_decode i_dma_window_decode (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_chan(req_chan), .err_clear(err_clear),
    .rsp_valid(rsp_valid), .rsp_region(rsp_region), .rsp_offset(rsp_offset),
    .err_pulse(err_pulse), .stat_set(stat_set), .stop_pulse(stop_pulse),
    .stop_chan(stop_chan), .buserr_flag(buserr_flag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input bit wr, input logic [CW-1:0] ch, input bit clr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_chan = ch; err_clear = clr;
    @(negedge clk);
    req_valid = 1'b0; err_clear = 1'b0; req_addr = '0;
  endtask

  task automatic expect_ok(input logic [31:0] a, input bit wr, input logic [2:0] rg,
                           input logic [31:0] off, input string req);
    issue(a, wr, 4'd2, 1'b0);
    check(rsp_valid == 1'b1, {req, " valid"}, 32'(rsp_valid), 32'd1);
    check(rsp_region == rg, {req, " region"}, 32'(rsp_region), 32'(rg));
    check(rsp_offset == off, {req, " offset"}, rsp_offset, off);
    check(err_pulse == 1'b0 && stop_pulse == 1'b0 && stat_set == '0,
          {req, " no error pulse"}, 32'({err_pulse, stop_pulse}), 32'd0);
  endtask

  task automatic t_reset_R9;
    check(rsp_valid == 0 && rsp_region == 0 && rsp_offset == 0, "R9 response", rsp_offset, 0);
    check(err_pulse == 0 && stop_pulse == 0 && stat_set == 0 && stop_chan == 0 && buserr_flag == 0,
          "R9 error outputs", 32'(stat_set), 0);
  endtask

  task automatic t_flag_R1;
    expect_ok(32'hFFFF_FFF5, 1'b0, 3'd1, 32'h3FF0, "R1 flag all ones");
    expect_ok(32'h8000_0010, 1'b1, 3'd1, 32'h0010, "R1 flag write");
  endtask

  task automatic t_main_R3;
    expect_ok(32'h0000_1234, 1'b0, 3'd0, 32'h0000_1230, "R3 main low");
    expect_ok(32'h01FF_FFFF, 1'b1, 3'd0, 32'h01FF_FFF0, "R3 main top");
    expect_ok(32'h6000_0048, 1'b0, 3'd0, 32'h0000_0040, "R2 bits 30 29 masked");
  endtask

  task automatic t_sink_R4;
    expect_ok(32'h0200_0000, 1'b0, 3'd2, 32'h0, "R4 sink read");
    expect_ok(32'h0FFF_FFFF, 1'b1, 3'd3, 32'h0, "R4 sink write");
  endtask

  task automatic t_spad_R5;
    expect_ok(32'h1000_0000, 1'b0, 3'd1, 32'h0000, "R5 window base");
    expect_ok(32'h1000_3FFF, 1'b1, 3'd1, 32'h3FF0, "R5 window top");
    expect_ok(32'h3000_2004, 1'b0, 3'd1, 32'h2000, "R2 R5 masked into window");
  endtask

  task automatic t_error_R6;
    issue(32'h1000_4000, 1'b0, 4'd5, 1'b0);
    check(rsp_valid && rsp_region == 3'd4 && rsp_offset == 0, "R6 error region", 32'(rsp_region), 32'd4);
    check(err_pulse && stop_pulse && stop_chan == 4'd5, "R6 stop channel", 32'(stop_chan), 32'd5);
    check(stat_set == 16'h0020, "R6 status bit", 32'(stat_set), 32'h20);
    check(buserr_flag == 1'b1, "R8 flag set", 32'(buserr_flag), 32'd1);
    @(negedge clk);
    check(!err_pulse && !stop_pulse && stat_set == 0 && !rsp_valid, "R7 single pulse",
          32'({err_pulse, stop_pulse, rsp_valid}), 32'd0);
    check(buserr_flag == 1'b1, "R8 flag held", 32'(buserr_flag), 32'd1);
    expect_ok(32'h0000_0100, 1'b0, 3'd0, 32'h100, "R8 ok request");
    check(buserr_flag == 1'b1, "R8 flag survives good request", 32'(buserr_flag), 32'd1);
  endtask

  task automatic t_clear_R8;
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0;
    check(buserr_flag == 1'b0, "R8 flag cleared", 32'(buserr_flag), 32'd0);
  endtask

  task automatic t_collide_R8;
    issue(32'h1FFF_FFF0, 1'b1, 4'd15, 1'b1);
    check(buserr_flag == 1'b1, "R8 set wins over clear", 32'(buserr_flag), 32'd1);
    check(stat_set == 16'h8000 && stop_chan == 4'd15, "R6 top channel", 32'(stat_set), 32'h8000);
  endtask

  task automatic t_idle_R7;
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0;
    req_addr = 32'h1800_0000; req_chan = 4'd3;
    @(negedge clk);
    check(!rsp_valid && !err_pulse && !stop_pulse && stat_set == 0, "R7 no strobe no pulse",
          32'(stat_set), 32'd0);
    check(buserr_flag == 1'b0, "R7 no strobe flag untouched", 32'(buserr_flag), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_R9();
    rst_n = 1'b1;
    @(negedge clk);
    t_flag_R1();
    t_main_R3();
    t_sink_R4();
    t_spad_R5();
    t_error_R6();
    t_clear_R8();
    t_collide_R8();
    t_idle_R7();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule